// File: doc/BRIEF.md
# Two-Level Table Entry Walker

The walker fetches one 64-bit table entry selected by an integer ID, for example a device ID or a collection ID. The caller presents the ID together with the table configuration: base address, page size, entry size and a flag that picks a flat or an indirect table. It then pulses `start_i`. The walker reads memory through a request/response port that carries one 64-bit little-endian read at a time. When it finishes it pulses `done_o` and returns the entry, an entry-valid flag and a memory-error flag.

A flat table takes one read. An indirect table takes two reads. The first fetches a level-1 descriptor. If that descriptor is marked valid, it supplies a pointer to a level-2 page, and the second read fetches the entry from that page. An invalid descriptor ends the walk early with an empty result. A bus error on any read ends the walk at once.

Page size and entry size are given as base-2 logarithms, so every divide and modulo becomes a shift or a mask. The caller must keep 3 <= `entry_lg_i` <= `page_lg_i`.

Top module: `tbl_walker`

## Requirements
- R1: After reset, `done_o`, `mem_req_o`, `valid_o` and `err_o` are low and `entry_o` is zero.
- R2: In flat mode (`indirect_i`=0) the walker issues exactly one read at `base_i + (id_i << entry_lg_i)` and returns the read data as `entry_o`.
- R3: In indirect mode (`indirect_i`=1) the first read is at `base_i + ((id_i >> (page_lg_i - 3)) << 3)`.
- R4: If bit 63 of the level-1 descriptor is 1, the second read is at `desc[50:0] + ((id_i mod 2^(page_lg_i - entry_lg_i)) << entry_lg_i)`. Descriptor bits 62:51 are ignored.
- R5: If bit 63 of the level-1 descriptor is 0, no second read is issued. The walk completes with `entry_o`=0, `valid_o`=0 and `err_o`=0.
- R6: On a completed read of the entry, `valid_o` equals bit 0 of `entry_o`.
- R7: A response with `mem_rerr_i`=1 on any read ends the walk. `done_o` rises in the next cycle with `err_o`=1, `valid_o`=0 and `entry_o`=0, and no further read is issued for that walk.
- R8: `done_o` is a one-cycle pulse in the cycle after the final response. `mem_req_o` is a one-cycle pulse, and the next request waits for the response to the previous one.
- R9: A `start_i` pulse while a walk is in progress is ignored. It causes no extra read and no extra `done_o`.
- R10: The ID and configuration inputs are sampled with `start_i`. Changing them during a walk does not alter its reads or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a lookup; honoured only when idle |
| id_i | input | ID_W | Lookup index |
| indirect_i | input | 1 | 1 = two-level table, 0 = flat |
| base_i | input | 64 | Table base address (flat table or level-1 array) |
| page_lg_i | input | PG_W | log2 of the page size in bytes |
| entry_lg_i | input | EL_W | log2 of the entry size in bytes |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 64 | Read address, valid with mem_req_o |
| mem_rvalid_i | input | 1 | Read response strobe |
| mem_rdata_i | input | 64 | Read response data |
| mem_rerr_i | input | 1 | Read response error |
| done_o | output | 1 | Walk finished pulse |
| entry_o | output | 64 | Fetched entry, held until the next done |
| valid_o | output | 1 | Entry-valid flag |
| err_o | output | 1 | Memory-error flag |

## Verification
The properties assume that memory raises `mem_rvalid_i` only while a read is outstanding, and for exactly one cycle per request. They also assume the configuration is legal: entry size of at least 8 bytes and no larger than the page. The bench's memory model answers every request once, after a fixed latency, and never responds unprompted. Every lookup the bench drives uses an entry-size log of 3 or 4 and a page-size log of 12 or 16.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned DESC_VLD_BIT = 63;
  localparam int unsigned ENT_VLD_BIT  = 0;
  localparam int unsigned L2_PTR_W     = 51;
  localparam int unsigned DESC_LG      = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_REQ,
    S_L1_WAIT,
    S_LF_REQ,
    S_LF_WAIT
  } tw_state_e;
endpackage

// File: rtl/tw_addr.sv
module tw_addr
  import tw_pkg::*;
#(
  parameter int unsigned ID_W = 20,
  parameter int unsigned PG_W = 5,
  parameter int unsigned EL_W = 3
) (
  input  logic [ID_W-1:0]     id_i,
  input  logic                indirect_i,
  input  logic                sel_l1_i,
  input  logic [63:0]         base_i,
  input  logic [PG_W-1:0]     page_lg_i,
  input  logic [EL_W-1:0]     entry_lg_i,
  input  logic [L2_PTR_W-1:0] l2_base_i,
  output logic [63:0]         addr_o
);
  logic [63:0]     id_w;
  logic [PG_W-1:0] l1_sh;
  logic [PG_W-1:0] slot_sh;
  logic [63:0]     l1_addr;
  logic [63:0]     slot_mask;
  logic [63:0]     leaf_addr;

  always_comb begin
    id_w      = 64'(id_i);
    l1_sh     = page_lg_i - PG_W'(DESC_LG);
    l1_addr   = base_i + ((id_w >> l1_sh) << DESC_LG);
    slot_sh   = page_lg_i - PG_W'(entry_lg_i);
    slot_mask = (64'd1 << slot_sh) - 64'd1;
    if (indirect_i)
      leaf_addr = 64'(l2_base_i) + ((id_w & slot_mask) << entry_lg_i);
    else
      leaf_addr = base_i + (id_w << entry_lg_i);
    addr_o = sel_l1_i ? l1_addr : leaf_addr;
  end
endmodule

// File: rtl/tw_fsm.sv
module tw_fsm
  import tw_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                indirect_i,
  input  logic                rvalid_i,
  input  logic [63:0]         rdata_i,
  input  logic                rerr_i,
  output logic                accept_o,
  output logic                req_o,
  output logic                sel_l1_o,
  output logic [L2_PTR_W-1:0] l2_base_o,
  output logic                done_o,
  output logic [63:0]         entry_o,
  output logic                valid_o,
  output logic                err_o
);
  tw_state_e   state_q, state_d;
  logic        fin;
  logic        fin_err;
  logic [63:0] fin_entry;

  assign accept_o = (state_q == S_IDLE) && start_i;
  assign req_o    = (state_q == S_L1_REQ) || (state_q == S_LF_REQ);
  assign sel_l1_o = (state_q == S_L1_REQ);

  always_comb begin
    state_d   = state_q;
    fin       = 1'b0;
    fin_err   = 1'b0;
    fin_entry = '0;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = indirect_i ? S_L1_REQ : S_LF_REQ;
      S_L1_REQ:  state_d = S_L1_WAIT;
      S_L1_WAIT: if (rvalid_i) begin
        if (rerr_i || !rdata_i[DESC_VLD_BIT]) begin
          fin     = 1'b1;
          fin_err = rerr_i;
        end else begin
          state_d = S_LF_REQ;
        end
      end
      S_LF_REQ:  state_d = S_LF_WAIT;
      S_LF_WAIT: if (rvalid_i) begin
        fin       = 1'b1;
        fin_err   = rerr_i;
        fin_entry = rerr_i ? 64'd0 : rdata_i;
      end
      default:   state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      l2_base_o <= '0;
      done_o    <= 1'b0;
      entry_o   <= '0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin;
      if (state_q == S_L1_WAIT && rvalid_i)
        l2_base_o <= rdata_i[L2_PTR_W-1:0];
      if (fin) begin
        entry_o <= fin_entry;
        valid_o <= !fin_err && fin_entry[ENT_VLD_BIT];
        err_o   <= fin_err;
      end
    end
  end
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import tw_pkg::*;
#(
  parameter int unsigned ID_W = 20,
  parameter int unsigned PG_W = 5,
  parameter int unsigned EL_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            indirect_i,
  input  logic [63:0]     base_i,
  input  logic [PG_W-1:0] page_lg_i,
  input  logic [EL_W-1:0] entry_lg_i,
  output logic            mem_req_o,
  output logic [63:0]     mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [63:0]     mem_rdata_i,
  input  logic            mem_rerr_i,
  output logic            done_o,
  output logic [63:0]     entry_o,
  output logic            valid_o,
  output logic            err_o
);
  logic                accept;
  logic                sel_l1;
  logic [L2_PTR_W-1:0] l2_base;
  logic [ID_W-1:0]     id_q;
  logic                ind_q;
  logic [63:0]         base_q;
  logic [PG_W-1:0]     plg_q;
  logic [EL_W-1:0]     elg_q;

  // lookup config is frozen for the whole walk
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      ind_q  <= 1'b0;
      base_q <= '0;
      plg_q  <= '0;
      elg_q  <= '0;
    end else if (accept) begin
      id_q   <= id_i;
      ind_q  <= indirect_i;
      base_q <= base_i;
      plg_q  <= page_lg_i;
      elg_q  <= entry_lg_i;
    end
  end

  tw_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .indirect_i (indirect_i),
    .rvalid_i   (mem_rvalid_i),
    .rdata_i    (mem_rdata_i),
    .rerr_i     (mem_rerr_i),
    .accept_o   (accept),
    .req_o      (mem_req_o),
    .sel_l1_o   (sel_l1),
    .l2_base_o  (l2_base),
    .done_o     (done_o),
    .entry_o    (entry_o),
    .valid_o    (valid_o),
    .err_o      (err_o)
  );

  tw_addr #(.ID_W(ID_W), .PG_W(PG_W), .EL_W(EL_W)) u_addr (
    .id_i       (id_q),
    .indirect_i (ind_q),
    .sel_l1_i   (sel_l1),
    .base_i     (base_q),
    .page_lg_i  (plg_q),
    .entry_lg_i (elg_q),
    .l2_base_i  (l2_base),
    .addr_o     (mem_addr_o)
  );
endmodule

// File: rtl/tbl_walker_chk.sv
module tbl_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_rvalid_i,
  input logic        mem_rerr_i,
  input logic        done_o,
  input logic [63:0] entry_o,
  input logic        valid_o,
  input logic        err_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (mem_req_o)    pend_q <= 1'b1;
    else if (mem_rvalid_i) pend_q <= 1'b0;
  end

  a_r8_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r8_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_err_ends_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rvalid_i && mem_rerr_i) |=> (done_o && err_o && !valid_o && entry_o == 64'd0 && !mem_req_o));

  a_r6_valid_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> entry_o[0]);

  a_r7_err_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!valid_o && entry_o == 64'd0));
endmodule

bind tbl_walker tbl_walker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rerr_i   (mem_rerr_i),
  .done_o       (done_o),
  .entry_o      (entry_o),
  .valid_o      (valid_o),
  .err_o        (err_o)
);

// File: tb/sim_tbl_walker.sv
`timescale 1ns/1ps
module sim_tbl_walker;
  localparam int ID_W = 20;
  localparam int PG_W = 5;
  localparam int EL_W = 3;
  localparam int LAT  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [ID_W-1:0] id = '0;
  logic            ind = 1'b0;
  logic [63:0]     base = '0;
  logic [PG_W-1:0] plg = 5'd12;
  logic [EL_W-1:0] elg = 3'd3;
  logic            mem_req;
  logic [63:0]     mem_addr;
  logic            rvalid = 1'b0;
  logic [63:0]     rdata = '0;
  logic            rerr = 1'b0;
  logic            done;
  logic [63:0]     entry;
  logic            valid;
  logic            err;

  always #2 clk = ~clk;

  tbl_walker #(.ID_W(ID_W), .PG_W(PG_W), .EL_W(EL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .id_i(id), .indirect_i(ind),
    .base_i(base), .page_lg_i(plg), .entry_lg_i(elg),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata), .mem_rerr_i(rerr), .done_o(done), .entry_o(entry),
    .valid_o(valid), .err_o(err));

  int errors = 0;
  int checks = 0;

  logic [63:0] mem [logic [63:0]];
  bit          bad [logic [63:0]];

  logic [63:0] ea_q [$];
  string       ea_tag [$];
  logic [65:0] er_q [$];
  string       er_tag [$];

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : {~a[31:0], a[31:1], 1'b0};
  endfunction

  function automatic logic [63:0] a_l1(input logic [63:0] b, input int i, input int pl);
    return b + ((64'(i) >> (pl - 3)) << 3);
  endfunction

  function automatic logic [63:0] a_leaf(input logic [63:0] d, input int i, input int pl, input int el);
    return 64'(d[50:0]) + ((64'(i) & ((64'd1 << (pl - el)) - 1)) << el);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected address stream and result, computed from the memory model
  task automatic plan(input string tag, input int i, input bit in, input logic [63:0] b,
                      input int pl, input int el);
    logic [63:0] a, d;
    logic [63:0] e;
    bit          r;
    e = 64'd0;
    r = 1'b0;
    if (in) begin
      a = a_l1(b, i, pl);
      ea_q.push_back(a); ea_tag.push_back(tag);
      d = rd(a);
      if (bad.exists(a)) r = 1'b1;
      else if (d[63]) begin
        a = a_leaf(d, i, pl, el);
        ea_q.push_back(a); ea_tag.push_back(tag);
        if (bad.exists(a)) r = 1'b1; else e = rd(a);
      end
    end else begin
      a = b + (64'(i) << el);
      ea_q.push_back(a); ea_tag.push_back(tag);
      if (bad.exists(a)) r = 1'b1; else e = rd(a);
    end
    er_q.push_back({r, !r && e[0], e}); er_tag.push_back(tag);
  endtask

  task automatic lookup(input string tag, input int i, input bit in, input logic [63:0] b,
                        input int pl, input int el);
    plan(tag, i, in, b, pl, el);
    @(negedge clk);
    id = ID_W'(i); ind = in; base = b; plg = PG_W'(pl); elg = EL_W'(el);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (er_q.size() == 0);
    @(negedge clk);
  endtask

  // memory model: one response LAT cycles after each request
  int          cnt = 0;
  logic [63:0] pa;
  always @(negedge clk) begin
    rvalid = 1'b0;
    rerr   = 1'b0;
    if (cnt != 0) begin
      cnt--;
      if (cnt == 0) begin
        rvalid = 1'b1;
        rerr   = bad.exists(pa);
        rdata  = rerr ? 64'hDEAD_BEEF_DEAD_BEEF : rd(pa);
      end
    end
    if (rst_n && mem_req) begin
      if (ea_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read act=%h exp=none", mem_addr);
      end else begin
        chk({ea_tag.pop_front(), " addr"}, mem_addr, ea_q.pop_front());
      end
      pa  = mem_addr;
      cnt = LAT;
    end
  end

  // result monitor
  logic done_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done_p && done) begin
      checks++; errors++;
      $display("FAIL R8 done width act=2 exp=1");
    end
    done_p = done;
    if (rst_n && done) begin
      if (er_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 extra done act=1 exp=0");
      end else begin
        logic [65:0] x;
        string       t;
        x = er_q.pop_front();
        t = er_tag.pop_front();
        chk({t, " entry"}, entry, x[63:0]);
        chk({t, " valid/err"}, {62'd0, err, valid}, {62'd0, x[65], x[64]});
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] d, a;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outs", {60'd0, done, mem_req, valid, err}, 64'd0);
    chk("R1 entry", entry, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R6 flat, valid entry
    mem[64'h1028] = 64'h0123_4567_89AB_CDEF;
    lookup("R2 flat el3", 5, 1'b0, 64'h1000, 12, 3);
    // R6 flat, entry bit0 clear
    mem[64'h2070] = 64'hFFFF_0000_1234_5678;
    lookup("R6 invalid entry", 7, 1'b0, 64'h2000, 12, 4);

    // R3 / R4 indirect with junk in descriptor bits 62:51
    a = a_l1(64'h4000_0000, 1000, 12);
    mem[a] = 64'hFFFF_0000_2000_0000;
    a = a_leaf(64'hFFFF_0000_2000_0000, 1000, 12, 3);
    mem[a] = 64'hCAFE_F00D_0000_0011;
    lookup("R3 R4 indirect pg12", 1000, 1'b1, 64'h4000_0000, 12, 3);

    // R4 larger page, 16-byte entries
    d = 64'h8000_0000_0055_0000;
    a = a_l1(64'h8_0000, 20'hABCDE, 16);
    mem[a] = d;
    mem[a_leaf(d, 20'hABCDE, 16, 4)] = 64'h1111_2222_3333_4445;
    lookup("R4 indirect pg16", 20'hABCDE, 1'b1, 64'h8_0000, 16, 4);

    // R5 level-1 descriptor invalid
    a = a_l1(64'h9000, 3000, 12);
    mem[a] = 64'h7FFF_FFFF_FFFF_FFFF;
    lookup("R5 l1 invalid", 3000, 1'b1, 64'h9000, 12, 3);

    // R7 errors at each read
    bad[64'h5000 + (64'd9 << 3)] = 1'b1;
    lookup("R7 flat err", 9, 1'b0, 64'h5000, 12, 3);
    a = a_l1(64'h6000, 700, 12);
    bad[a] = 1'b1;
    lookup("R7 l1 err", 700, 1'b1, 64'h6000, 12, 3);
    d = 64'h8000_0000_0077_0000;
    a = a_l1(64'h7000, 600, 12);
    mem[a] = d;
    bad[a_leaf(d, 600, 12, 3)] = 1'b1;
    lookup("R7 leaf err", 600, 1'b1, 64'h7000, 12, 3);

    // R9 / R10 start pulses and input changes during a walk
    d = 64'h8000_0000_0033_0000;
    a = a_l1(64'hA000, 1234, 12);
    mem[a] = d;
    mem[a_leaf(d, 1234, 12, 3)] = 64'h0BAD_C0DE_0000_0001;
    plan("R9 R10 busy", 1234, 1'b1, 64'hA000, 12, 3);
    @(negedge clk);
    id = 20'd1234; ind = 1'b1; base = 64'hA000; plg = 5'd12; elg = 3'd3;
    start = 1'b1;
    @(negedge clk);
    id = 20'd77; ind = 1'b0; base = 64'hF000; plg = 5'd16; elg = 3'd4;
    for (int k = 0; k < 6; k++) begin
      start = (k % 2 == 0);
      @(negedge clk);
    end
    start = 1'b0;
    wait (er_q.size() == 0);
    repeat (8) @(negedge clk);
    chk("R9 no extra read", 64'(ea_q.size()), 64'd0);

    // R2 flat after an indirect walk
    mem[64'h3000 + (64'd12 << 3)] = 64'h5A5A_5A5A_5A5A_5A5B;
    lookup("R2 flat after ind", 12, 1'b0, 64'h3000, 12, 3);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule